// File: doc/BRIEF.md
# Hold-Over Frequency Averager

This block builds the frequency word a disciplined oscillator falls back on when it loses its timing reference. While the loop is locked, the loop filter presents its frequency control word with a valid strobe, and a once-per-second tick drives the averaging. At each accepted tick the most recent captured word is added into a block of eight seconds. Finished blocks go into a circular window of 131 blocks, which covers 1048 seconds of history. A running total over the window, scaled by a constant reciprocal taken from a table indexed by the number of filled blocks, gives the mean.

The average counts as qualified once 701 accepted seconds have gone by since reset or since the last reference change. From then on it is recomputed at every block boundary. Each new average also passes through a four-stage delay line. The word offered for hold over therefore trails the newest average by 32 seconds, which leaves time to act on a frequency-limit alarm before a corrupt value is used. Until the first value reaches the end of that line, the offered word is the nominal free-run word. A loss-of-reference or fast-acquisition flag freezes the whole block. A reference change restarts the window and the timer, but the last delivered word is kept.

Top module: `holdover_avg`

## Requirements
- R1: After reset, `avg_qual` is 0 and both `avg_word` and `ho_word` equal the nominal word (default 0x800000).
- R2: `avg_qual` goes high on the 701st accepted tick counted from reset or from the last `ref_chg`, and not on any earlier tick. A tick is accepted when `sec_tick` is high and `los_inhibit`, `fastacq_inhibit` and `ref_chg` are all low.
- R3: While qualified, every 8th accepted tick closes a block. Two clock edges after that tick, `avg_word` equals floor(S / (8·N)), where N is the number of stored blocks and S is the sum of the per-second words in them. The per-second word is the last `freq_word` captured with `freq_vld` before the tick. `avg_word` never changes while `avg_qual` is low.
- R4: The window keeps only the newest 131 blocks. When a block is added to a full window, the oldest block leaves the sum.
- R5: While `los_inhibit` or `fastacq_inhibit` is high, ticks are not counted and `freq_vld` captures nothing. The timer, the window, `avg_word`, `avg_qual` and `ho_word` all stay as they are.
- R6: `ho_word` equals the nominal word until the first averaged value has passed through the delay line.
- R7: An average computed at one update becomes `ho_word` at the 4th update after it, which is 32 accepted seconds later. `ho_word` changes only while qualified.
- R8: `ref_chg` clears the window, the qualification timer, `avg_qual` and the delay line on the next edge. `avg_word` and `ho_word` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word | input | 24 | Frequency control word from the loop filter |
| freq_vld | input | 1 | Capture strobe for `freq_word` |
| sec_tick | input | 1 | One-cycle pulse once per second |
| ref_chg | input | 1 | One-cycle pulse on reference selection or switch |
| los_inhibit | input | 1 | Loss of reference active, freezes the block |
| fastacq_inhibit | input | 1 | Fast acquisition active, freezes the block |
| avg_word | output | 24 | Newest window average |
| avg_qual | output | 1 | Average qualified (701 s of history gathered) |
| ho_word | output | 24 | Word applied on entry into hold over |

## Verification
A fault in the window shows up in `avg_word` two cycles after the block-closing tick. A slot that is never evicted or a wrong running total gives a mixed value once the window wraps. A stale total left behind by a reference change gives a blend at the first block after requalification. A delay line of the wrong depth moves the change of `ho_word` one update (8 ticks) early or late. A timer that counts frozen ticks raises `avg_qual` or moves `avg_word` during an inhibit window, so the error is visible at the ports within one tick.

// File: rtl/hoa_pkg.sv
package hoa_pkg;

    // Rounded-up reciprocal 2^shift / div, used as a constant multiplier.
    function automatic logic [63:0] ceil_recip(input int unsigned shift, input int unsigned div);
        logic [63:0] num;
        num = (64'd1 << shift) + 64'(div) - 64'd1;
        return num / 64'(div);
    endfunction

endpackage

// File: rtl/hoa_blk_window.sv
module hoa_blk_window #(
    parameter int BLK_W    = 27,
    parameter int TOTAL_W  = 35,
    parameter int NUM_BLKS = 131,
    parameter int FILL_W   = $clog2(NUM_BLKS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               push,
    input  logic [BLK_W-1:0]   blk_sum,
    output logic [TOTAL_W-1:0] total,
    output logic [FILL_W-1:0]  fill
);
    localparam int PTR_W = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1;

    typedef struct packed {
        logic [NUM_BLKS-1:0][BLK_W-1:0] slot;
        logic [PTR_W-1:0]               ptr;
        logic [FILL_W-1:0]              fill;
        logic [TOTAL_W-1:0]             total;
    } win_t;

    win_t win_d, win_q;
    logic [TOTAL_W-1:0] evict;

    always_comb begin
        win_d = win_q;
        evict = (win_q.fill == FILL_W'(NUM_BLKS)) ? TOTAL_W'(win_q.slot[win_q.ptr]) : '0;
        if (clr) begin
            win_d.total = '0;
            win_d.fill  = '0;
            win_d.ptr   = '0;
        end else if (push) begin
            win_d.slot[win_q.ptr] = blk_sum;
            win_d.total = win_q.total - evict + TOTAL_W'(blk_sum);
            win_d.ptr   = (win_q.ptr == PTR_W'(NUM_BLKS - 1)) ? '0 : win_q.ptr + PTR_W'(1);
            if (win_q.fill != FILL_W'(NUM_BLKS)) begin
                win_d.fill = win_q.fill + FILL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign total = win_q.total;
    assign fill  = win_q.fill;

endmodule

// File: rtl/hoa_recip_div.sv
module hoa_recip_div #(
    parameter int WORD_W       = 24,
    parameter int TOTAL_W      = 35,
    parameter int NUM_BLKS     = 131,
    parameter int SECS_PER_BLK = 8,
    parameter int FILL_W       = $clog2(NUM_BLKS + 1),
    parameter int SHIFT        = 46,
    parameter int RECIP_W      = 44
) (
    input  logic [TOTAL_W-1:0] total,
    input  logic [FILL_W-1:0]  fill,
    output logic [WORD_W-1:0]  quot
);
    localparam int PROD_W = TOTAL_W + RECIP_W;

    logic [RECIP_W-1:0] recip_tab [NUM_BLKS];
    logic [RECIP_W-1:0] sel;
    logic [FILL_W-1:0]  idx;
    logic [PROD_W-1:0]  product;

    // One constant per possible fill level, divisor = seconds held.
    for (genvar g = 0; g < NUM_BLKS; g++) begin : g_recip
        assign recip_tab[g] = RECIP_W'(hoa_pkg::ceil_recip(SHIFT, SECS_PER_BLK * (g + 1)));
    end

    always_comb begin
        idx     = fill - FILL_W'(1);
        sel     = (fill == '0) ? '0 : recip_tab[idx];
        product = PROD_W'(total) * PROD_W'(sel);
        quot    = WORD_W'(product >> SHIFT);
    end

endmodule

// File: rtl/hoa_delay_line.sv
module hoa_delay_line #(
    parameter int WORD_W = 24,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] tail,
    output logic              tail_vld
);
    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] data;
        logic [DEPTH-1:0]             vld;
    } dly_t;

    dly_t dly_d, dly_q;

    always_comb begin
        dly_d = dly_q;
        if (clr) begin
            dly_d.vld = '0;
        end else if (shift) begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                dly_d.data[i] = dly_q.data[i-1];
                dly_d.vld[i]  = dly_q.vld[i-1];
            end
            dly_d.data[0] = din;
            dly_d.vld[0]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= '0;
        else        dly_q <= dly_d;
    end

    assign tail     = dly_q.data[DEPTH-1];
    assign tail_vld = dly_q.vld[DEPTH-1];

endmodule

// File: rtl/holdover_avg.sv
module holdover_avg #(
    parameter int                WORD_W       = 24,
    parameter int                SECS_PER_BLK = 8,
    parameter int                NUM_BLKS     = 131,
    parameter int                QUAL_SECS    = 701,
    parameter int                DELAY_UPD    = 4,
    parameter logic [WORD_W-1:0] NOMINAL_WORD = {1'b1, {(WORD_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] freq_word,
    input  logic              freq_vld,
    input  logic              sec_tick,
    input  logic              ref_chg,
    input  logic              los_inhibit,
    input  logic              fastacq_inhibit,
    output logic [WORD_W-1:0] avg_word,
    output logic              avg_qual,
    output logic [WORD_W-1:0] ho_word
);
    localparam int BLK_W   = WORD_W + $clog2(SECS_PER_BLK);
    localparam int CNT_W   = $clog2(SECS_PER_BLK * NUM_BLKS + 1);
    localparam int TOTAL_W = WORD_W + CNT_W;
    localparam int SHIFT   = WORD_W + 2 * CNT_W;
    localparam int RECIP_W = SHIFT - $clog2(SECS_PER_BLK) + 1;
    localparam int FILL_W  = $clog2(NUM_BLKS + 1);
    localparam int SIB_W   = $clog2(SECS_PER_BLK + 1);
    localparam int SEC_W   = $clog2(QUAL_SECS + 1);

    typedef struct packed {
        logic [WORD_W-1:0] cur;
        logic [BLK_W-1:0]  acc;
        logic [SIB_W-1:0]  sib;
        logic [SEC_W-1:0]  secs;
        logic              qual;
        logic              pend;
        logic [WORD_W-1:0] avg;
        logic [WORD_W-1:0] good;
        logic              have_good;
    } st_t;

    localparam st_t ST_RST = '{cur: NOMINAL_WORD, avg: NOMINAL_WORD, default: '0};

    st_t st_d, st_q;

    logic               inhibit, tick_ok, push, shift;
    logic [BLK_W-1:0]   blk_sum;
    logic [TOTAL_W-1:0] win_total;
    logic [FILL_W-1:0]  win_fill;
    logic [WORD_W-1:0]  quot, tail;
    logic               tail_vld;

    hoa_blk_window #(
        .BLK_W(BLK_W), .TOTAL_W(TOTAL_W), .NUM_BLKS(NUM_BLKS), .FILL_W(FILL_W)
    ) win_i (
        .clk(clk), .rst_n(rst_n), .clr(ref_chg), .push(push),
        .blk_sum(blk_sum), .total(win_total), .fill(win_fill)
    );

    hoa_recip_div #(
        .WORD_W(WORD_W), .TOTAL_W(TOTAL_W), .NUM_BLKS(NUM_BLKS),
        .SECS_PER_BLK(SECS_PER_BLK), .FILL_W(FILL_W), .SHIFT(SHIFT), .RECIP_W(RECIP_W)
    ) div_i (
        .total(win_total), .fill(win_fill), .quot(quot)
    );

    hoa_delay_line #(
        .WORD_W(WORD_W), .DEPTH(DELAY_UPD)
    ) dly_i (
        .clk(clk), .rst_n(rst_n), .clr(ref_chg), .shift(shift),
        .din(quot), .tail(tail), .tail_vld(tail_vld)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pend = 1'b0;
        push    = 1'b0;
        shift   = 1'b0;
        inhibit = los_inhibit | fastacq_inhibit;
        tick_ok = sec_tick & ~inhibit & ~ref_chg;
        blk_sum = st_q.acc + BLK_W'(st_q.cur);

        if (freq_vld && !inhibit) begin
            st_d.cur = freq_word;
        end

        if (ref_chg) begin
            st_d.acc  = '0;
            st_d.sib  = '0;
            st_d.secs = '0;
            st_d.qual = 1'b0;
        end else begin
            // Second cycle of an update: window total is settled.
            if (st_q.pend) begin
                shift    = 1'b1;
                st_d.avg = quot;
                if (tail_vld) begin
                    st_d.good      = tail;
                    st_d.have_good = 1'b1;
                end
            end
            if (tick_ok) begin
                if (st_q.secs != SEC_W'(QUAL_SECS)) begin
                    st_d.secs = st_q.secs + SEC_W'(1);
                    if (st_q.secs == SEC_W'(QUAL_SECS - 1)) begin
                        st_d.qual = 1'b1;
                    end
                end
                if (st_q.sib == SIB_W'(SECS_PER_BLK - 1)) begin
                    push      = 1'b1;
                    st_d.acc  = '0;
                    st_d.sib  = '0;
                    st_d.pend = st_d.qual;
                end else begin
                    st_d.acc = blk_sum;
                    st_d.sib = st_q.sib + SIB_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign avg_word = st_q.avg;
    assign avg_qual = st_q.qual;
    assign ho_word  = st_q.have_good ? st_q.good : NOMINAL_WORD;

endmodule

// File: rtl/hoa_checker.sv
module hoa_checker #(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              ref_chg,
    input logic              los_inhibit,
    input logic              fastacq_inhibit,
    input logic [WORD_W-1:0] avg_word,
    input logic              avg_qual,
    input logic [WORD_W-1:0] ho_word
);
    logic inh;
    assign inh = los_inhibit | fastacq_inhibit;

    // R2
    qual_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avg_qual) |-> $past(sec_tick && !inh && !ref_chg));

    // R3
    avg_moves_when_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(avg_word) |-> avg_qual);

    // R5
    inhibit_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inh && $past(inh) && !ref_chg) |=> ($stable(avg_word) && $stable(avg_qual) && $stable(ho_word)));

    // R7
    ho_moves_when_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ho_word) |-> avg_qual);

    // R8
    ref_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_chg |=> (!avg_qual && $stable(ho_word) && $stable(avg_word)));

endmodule

bind holdover_avg hoa_checker #(.WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ref_chg(ref_chg),
    .los_inhibit(los_inhibit), .fastacq_inhibit(fastacq_inhibit),
    .avg_word(avg_word), .avg_qual(avg_qual), .ho_word(ho_word)
);

// File: tb/holdover_avg_tb_top.sv
module holdover_avg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;
    localparam logic [23:0] NOM  = 24'h800000;
    localparam logic [23:0] WA   = 24'h100000;
    localparam logic [23:0] WB   = 24'h300000;
    localparam logic [23:0] MIX1 = 24'((64'd93 * 64'(WA) + 64'(WB)) / 64'd94);
    localparam logic [23:0] MIX2 = 24'((64'd4 * 64'(WA) + 64'd127 * 64'(WB)) / 64'd131);

    typedef struct packed {
        logic [23:0] word;
        logic        vld;
        logic        los;
        logic        fa;
        logic [15:0] ticks;
        logic        qual;
        logic [23:0] avg;
        logic [23:0] ho;
    } vec_t;

    // Running second count after each row in comments.
    localparam vec_t VECS [NVEC] = '{
        '{WA, 1'b1, 1'b0, 1'b0, 16'd700,  1'b0, NOM,  NOM },  // 700: not yet qualified
        '{WA, 1'b1, 1'b0, 1'b0, 16'd1,    1'b1, NOM,  NOM },  // 701: qualified
        '{WA, 1'b1, 1'b0, 1'b0, 16'd3,    1'b1, WA,   NOM },  // 704: first average
        '{WA, 1'b1, 1'b0, 1'b0, 16'd28,   1'b1, WA,   NOM },  // 732: still in delay
        '{WA, 1'b1, 1'b0, 1'b0, 16'd4,    1'b1, WA,   WA  },  // 736: delivered
        '{WB, 1'b1, 1'b1, 1'b0, 16'd48,   1'b1, WA,   WA  },  // R5 loss of ref frozen
        '{WB, 1'b0, 1'b0, 1'b0, 16'd8,    1'b1, WA,   WA  },  // 744: WB capture was ignored
        '{WB, 1'b1, 1'b0, 1'b1, 16'd16,   1'b1, WA,   WA  },  // R5 fast acquisition frozen
        '{WB, 1'b1, 1'b0, 1'b0, 16'd8,    1'b1, MIX1, WA  },  // 752: 93 A + 1 B blocks
        '{WB, 1'b1, 1'b0, 1'b0, 16'd1040, 1'b1, WB,   MIX2},  // R4 1792: all A evicted
        '{WB, 1'b1, 1'b0, 1'b0, 16'd32,   1'b1, WB,   WB  }   // 1824
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] freq_word = '0;
    logic        freq_vld = 1'b0;
    logic        sec_tick = 1'b0;
    logic        ref_chg = 1'b0;
    logic        los_inhibit = 1'b0;
    logic        fastacq_inhibit = 1'b0;
    logic [23:0] avg_word;
    logic        avg_qual;
    logic [23:0] ho_word;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    holdover_avg dut_i (
        .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .freq_vld(freq_vld),
        .sec_tick(sec_tick), .ref_chg(ref_chg), .los_inhibit(los_inhibit),
        .fastacq_inhibit(fastacq_inhibit), .avg_word(avg_word), .avg_qual(avg_qual),
        .ho_word(ho_word)
    );

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sec_tick = 1'b1;
            @(negedge clk) sec_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic load(input logic [23:0] w, input logic v);
        @(negedge clk);
        freq_word = w;
        freq_vld  = v;
        @(negedge clk) freq_vld = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        vec_t cv;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 qual", {23'd0, avg_qual}, 24'd0);
        chk("R1 avg", avg_word, NOM);
        chk("R1 ho", ho_word, NOM);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            cv = VECS[v];
            @(negedge clk);
            los_inhibit     = cv.los;
            fastacq_inhibit = cv.fa;
            load(cv.word, cv.vld);
            do_ticks(int'(cv.ticks));
            chk("R2/R5 qual", {23'd0, avg_qual}, {23'd0, cv.qual});
            chk("R3/R4 avg", avg_word, cv.avg);
            chk("R6/R7 ho", ho_word, cv.ho);
        end

        // R8 reference change restarts the averaging
        @(negedge clk) ref_chg = 1'b1;
        @(negedge clk) ref_chg = 1'b0;
        chk("R8 qual cleared", {23'd0, avg_qual}, 24'd0);
        chk("R8 avg kept", avg_word, WB);
        chk("R8 ho kept", ho_word, WB);
        load(WA, 1'b1);
        do_ticks(700);
        chk("R2 qual after 700", {23'd0, avg_qual}, 24'd0);
        do_ticks(1);
        chk("R2 qual after 701", {23'd0, avg_qual}, 24'd1);
        do_ticks(3);
        chk("R8 window cleared", avg_word, WA);
        do_ticks(31);
        chk("R7 ho before delivery", ho_word, WB);
        do_ticks(1);
        chk("R7 ho delivered", ho_word, WA);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule